// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns stereo PCM sample pairs into a serial data stream for an audio converter. The bit clock and the left/right (frame) clock come in from outside and are sampled by the block's system clock. Serial data changes in the system clock cycle in which a falling bit-clock edge is seen, so the receiver can sample it on the next rising edge. One shifter path serves four framings: right-justified, left-justified, the standard inter-IC sound framing with its one-bit delay, and a DSP framing in which a short frame-sync pulse is followed by both words back to back.

A 6-bit control word selects the framing, the word length (16, 20, 24 or 32 bits), a left/right swap and the level of the frame clock that marks the left half. A new sample pair is taken through a valid/ready handshake at the start of each frame. If no pair is offered at that moment, the frame carries zeros and a one-cycle underflow pulse follows. Samples are right-aligned in the input words, and only the low bits selected by the word length are sent.

Top module: `audio_fmt_tx`

## Requirements
- R1: During and just after reset, `sdata_o`, `underflow_o` and `s_ready_o` are 0.
- R2: A bit-clock falling edge is a system clock cycle in which `bclk_i` is 0 and was 1 in the previous cycle. `sdata_o` changes only at the clock edge that ends such a cycle and holds its value between falls.
- R3: With framing code 1 (`cfg_i[1:0]`=1, left-justified), the MSB goes out on the first fall of a half frame (position 0), and the LSB goes out at position W-1. Position p counts the falls since the frame clock last changed level.
- R4: With framing code 2 (`cfg_i[1:0]`=2), the MSB goes out at position 1 and the LSB goes out at position W.
- R5: With framing code 0 (`cfg_i[1:0]`=0, right-justified), the LSB goes out at position HALF_BITS-1 and the MSB goes out at position HALF_BITS-W. The line is 0 before the MSB.
- R6: With framing code 3 (`cfg_i[1:0]`=3), a frame starts at a fall where the frame clock is seen high after being low. The left word occupies frame positions 1..W and the right word occupies positions W+1..2W.
- R7: The length field `cfg_i[3:2]` selects W: 0 gives 16, 1 gives 20, 2 gives 24, 3 gives 32. Bits W-1..0 of each input word are sent. W is captured at frame start, so a change made mid-frame applies from the next frame.
- R8: When the swap bit `cfg_i[5]` is 1, the right input word is sent in the left slot and the left input word in the right slot.
- R9: The phase bit `cfg_i[4]` sets the frame-clock level of the left half. With the bit at 0, the left half is sent while the frame clock is low and the right half while it is high. With the bit at 1, the levels are reversed. In the three non-DSP framings, a frame starts at the first fall of a left half.
- R10: `s_ready_o` is 1 exactly in the system clock cycle of a frame start. The pair is accepted when `s_valid_i` is also 1.
- R11: If `s_valid_i` is 0 at a frame start, `underflow_o` is 1 for the following clock cycle only, and both words of that frame are sent as zeros.
- R12: Every fall whose position lies outside the active word of the selected framing drives `sdata_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_i | input | 6 | Control: [5] swap, [4] phase, [3:2] length, [1:0] framing |
| bclk_i | input | 1 | Bit clock, synchronous to clk and slower than it |
| lrclk_i | input | 1 | Frame (left/right) clock, changes with bit-clock falls |
| s_valid_i | input | 1 | A sample pair is offered |
| s_ready_o | output | 1 | Pair taken this cycle (frame start) |
| s_left_i | input | DW | Left sample, right-aligned |
| s_right_i | input | DW | Right sample, right-aligned |
| sdata_o | output | 1 | Serial data, MSB first |
| underflow_o | output | 1 | One-cycle pulse after a frame start with no pair |

## Verification
Each of the four framings is run with random sample pairs at several word lengths. A bit that shows up one position early or late, or a missing delay slot, therefore shows up as a mismatch against the position-by-position reference. The swap and phase bits are crossed with different framings, so that an exchange of channels can be told apart from an exchange of frame-clock levels. A length change placed in the middle of a frame separates a word length captured at frame start from one read live. Frames with the source starved separate the zero-fill and underflow pulse from a stale replay of the previous pair.

// File: rtl/audio_tx_pkg.sv
// Shared types and helpers for the audio serial transmitter.
package audio_tx_pkg;

    // Framing selection, value is the control-word code.
    typedef enum logic [1:0] {
        FMT_RJ  = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_I2S = 2'd2,
        FMT_DSP = 2'd3
    } fmt_e;

    // Control word layout, MSB first.
    typedef struct packed {
        logic       swap;
        logic       phase;
        logic [1:0] len;
        fmt_e       fmt;
    } ctl_t;

    // Word length in bits for a length code.
    function automatic int word_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/atx_frame_track.sv
// Frame tracker: finds bit-clock falls and frame starts and reports
// the position of the bit to send at each fall.
// Assumes bclk_i and lrclk_i are synchronous to clk, and that lrclk_i
// only changes in cycles where bclk_i falls.
module atx_frame_track
    import audio_tx_pkg::*;
#(
    parameter int HALF_BITS = 32,
    parameter int PW        = $clog2(2 * HALF_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk_i,
    input  logic          lrclk_i,
    input  fmt_e          fmt_i,
    input  logic          phase_i,
    output logic          fall_o,
    output logic          frame_start_o,
    output logic          right_half_o,
    output logic [PW-1:0] hpos_o,
    output logic [PW-1:0] fpos_o
);

    localparam logic [PW-1:0] POS_MAX = '1;

    logic          bclk_q;
    logic          lr_q;
    logic [PW-1:0] hpos_q;
    logic [PW-1:0] fpos_q;
    logic          fall;
    logic          half_start;
    logic          frame_start;
    logic [PW-1:0] hpos_nxt;
    logic [PW-1:0] fpos_nxt;

    // Edge detection and next positions for the bit sent at this fall.
    always_comb begin
        fall        = bclk_q & ~bclk_i;
        half_start  = fall && (lrclk_i != lr_q);
        if (fmt_i == FMT_DSP) begin
            frame_start = fall && lrclk_i && !lr_q;
        end else begin
            frame_start = half_start && (lrclk_i == phase_i);
        end
        if (half_start) begin
            hpos_nxt = '0;
        end else if (hpos_q == POS_MAX) begin
            hpos_nxt = hpos_q;
        end else begin
            hpos_nxt = hpos_q + PW'(1);
        end
        if (frame_start) begin
            fpos_nxt = '0;
        end else if (fpos_q == POS_MAX) begin
            fpos_nxt = fpos_q;
        end else begin
            fpos_nxt = fpos_q + PW'(1);
        end
    end

    // Hold last bit-clock level, and frame level and positions at each fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            lr_q   <= 1'b0;
            hpos_q <= POS_MAX;
            fpos_q <= POS_MAX;
        end else begin
            bclk_q <= bclk_i;
            if (fall) begin
                lr_q   <= lrclk_i;
                hpos_q <= hpos_nxt;
                fpos_q <= fpos_nxt;
            end
        end
    end

    assign fall_o        = fall;
    assign frame_start_o = frame_start;
    assign right_half_o  = (lrclk_i != phase_i);
    assign hpos_o        = hpos_nxt;
    assign fpos_o        = fpos_nxt;

    // R3: inside a half frame the position advances by one per fall.
    p_pos_step_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (fall && (lrclk_i == lr_q) && (hpos_q != POS_MAX))
            |=> (hpos_q == $past(hpos_q) + PW'(1)));

endmodule

// File: rtl/atx_sample_hold.sv
// Sample holder: takes a pair at frame start, applies the channel swap,
// captures the word length and flags underflow. The values in effect for
// the current frame are bypassed in the frame-start cycle itself.
module atx_sample_hold #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start_i,
    input  logic          swap_i,
    input  logic [1:0]    len_i,
    input  logic          valid_i,
    input  logic [DW-1:0] left_i,
    input  logic [DW-1:0] right_i,
    output logic          ready_o,
    output logic          underflow_o,
    output logic [DW-1:0] left_o,
    output logic [DW-1:0] right_o,
    output logic [1:0]    len_o
);

    logic [DW-1:0] left_q;
    logic [DW-1:0] right_q;
    logic [1:0]    len_q;
    logic          uflow_q;
    logic [DW-1:0] left_nxt;
    logic [DW-1:0] right_nxt;

    // Words loaded at frame start: swapped pair, or zeros on a miss.
    always_comb begin
        left_nxt  = '0;
        right_nxt = '0;
        if (valid_i) begin
            left_nxt  = swap_i ? right_i : left_i;
            right_nxt = swap_i ? left_i  : right_i;
        end
    end

    // Hold the current frame's words and length; raise the miss pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
            len_q   <= 2'd0;
            uflow_q <= 1'b0;
        end else begin
            uflow_q <= frame_start_i && !valid_i;
            if (frame_start_i) begin
                left_q  <= left_nxt;
                right_q <= right_nxt;
                len_q   <= len_i;
            end
        end
    end

    assign ready_o     = frame_start_i;
    assign underflow_o = uflow_q;
    assign left_o      = frame_start_i ? left_nxt  : left_q;
    assign right_o     = frame_start_i ? right_nxt : right_q;
    assign len_o       = frame_start_i ? len_i     : len_q;

    // R11: an underflow pulse only follows a cycle with no pair offered.
    p_uflow_needs_miss_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> !$past(valid_i));

    // R11: a missed frame holds zero words.
    p_zero_after_miss_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_i && !valid_i) |=> ((left_q == '0) && (right_q == '0)));

    // R10: an accepted pair never raises underflow.
    p_accept_no_uflow_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && valid_i) |=> !underflow_o);

endmodule

// File: rtl/atx_bit_serial.sv
// Bit serialiser: picks the bit for the current position under the
// selected framing and registers it on each bit-clock fall.
// Assumes HALF_BITS >= DW and DW >= 32 so every word length fits.
module atx_bit_serial
    import audio_tx_pkg::*;
#(
    parameter int DW        = 32,
    parameter int HALF_BITS = 32,
    parameter int PW        = $clog2(2 * HALF_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall_i,
    input  fmt_e          fmt_i,
    input  logic          right_half_i,
    input  logic [PW-1:0] hpos_i,
    input  logic [PW-1:0] fpos_i,
    input  logic [DW-1:0] left_i,
    input  logic [DW-1:0] right_i,
    input  logic [1:0]    len_i,
    output logic          sdata_o
);

    localparam int SW = $clog2(DW);

    logic          sdata_q;
    logic          bit_nxt;
    logic [DW-1:0] word;
    logic [DW-1:0] shifted;
    int            wlen;
    int            hp;
    int            fp;

    // Select the bit for this position; zero outside the active word.
    always_comb begin
        wlen    = word_bits(len_i);
        hp      = int'(hpos_i);
        fp      = int'(fpos_i);
        word    = right_half_i ? right_i : left_i;
        shifted = '0;
        bit_nxt = 1'b0;
        case (fmt_i)
            FMT_LJ: begin
                if (hp < wlen) begin
                    shifted = word >> SW'(wlen - 1 - hp);
                    bit_nxt = shifted[0];
                end
            end
            FMT_I2S: begin
                if ((hp >= 1) && (hp <= wlen)) begin
                    shifted = word >> SW'(wlen - hp);
                    bit_nxt = shifted[0];
                end
            end
            FMT_RJ: begin
                if ((hp >= HALF_BITS - wlen) && (hp < HALF_BITS)) begin
                    shifted = word >> SW'(HALF_BITS - 1 - hp);
                    bit_nxt = shifted[0];
                end
            end
            default: begin
                if ((fp >= 1) && (fp <= wlen)) begin
                    shifted = left_i >> SW'(wlen - fp);
                    bit_nxt = shifted[0];
                end else if ((fp > wlen) && (fp <= 2 * wlen)) begin
                    shifted = right_i >> SW'(2 * wlen - fp);
                    bit_nxt = shifted[0];
                end
            end
        endcase
    end

    // Update the data line only on a bit-clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata_q <= 1'b0;
        end else if (fall_i) begin
            sdata_q <= bit_nxt;
        end
    end

    assign sdata_o = sdata_q;

    // R2: the data line holds between falls.
    p_hold_between_falls_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> $stable(sdata_o));

    // R6: DSP positions past both longest words send zero.
    p_dsp_tail_zero_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && (fmt_i == FMT_DSP) && (int'(fpos_i) > 2 * DW)) |=> !sdata_o);

endmodule

// File: rtl/audio_fmt_tx.sv
// Multi-format audio serial transmitter top: splits the control word and
// connects the frame tracker, sample holder and bit serialiser.
// Assumes bit and frame clocks are synchronous to clk and slower than it.
module audio_fmt_tx
    import audio_tx_pkg::*;
#(
    parameter int DW        = 32,
    parameter int HALF_BITS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [5:0]    cfg_i,
    input  logic          bclk_i,
    input  logic          lrclk_i,
    input  logic          s_valid_i,
    output logic          s_ready_o,
    input  logic [DW-1:0] s_left_i,
    input  logic [DW-1:0] s_right_i,
    output logic          sdata_o,
    output logic          underflow_o
);

    localparam int PW = $clog2(2 * HALF_BITS + 1);

    ctl_t          ctl;
    logic          fall;
    logic          frame_start;
    logic          right_half;
    logic [PW-1:0] hpos;
    logic [PW-1:0] fpos;
    logic [DW-1:0] cur_left;
    logic [DW-1:0] cur_right;
    logic [1:0]    cur_len;

    assign ctl = ctl_t'(cfg_i);

    atx_frame_track #(
        .HALF_BITS (HALF_BITS),
        .PW        (PW)
    ) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .bclk_i        (bclk_i),
        .lrclk_i       (lrclk_i),
        .fmt_i         (ctl.fmt),
        .phase_i       (ctl.phase),
        .fall_o        (fall),
        .frame_start_o (frame_start),
        .right_half_o  (right_half),
        .hpos_o        (hpos),
        .fpos_o        (fpos)
    );

    atx_sample_hold #(
        .DW (DW)
    ) u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start),
        .swap_i        (ctl.swap),
        .len_i         (ctl.len),
        .valid_i       (s_valid_i),
        .left_i        (s_left_i),
        .right_i       (s_right_i),
        .ready_o       (s_ready_o),
        .underflow_o   (underflow_o),
        .left_o        (cur_left),
        .right_o       (cur_right),
        .len_o         (cur_len)
    );

    atx_bit_serial #(
        .DW        (DW),
        .HALF_BITS (HALF_BITS),
        .PW        (PW)
    ) u_serial (
        .clk          (clk),
        .rst_n        (rst_n),
        .fall_i       (fall),
        .fmt_i        (ctl.fmt),
        .right_half_i (right_half),
        .hpos_i       (hpos),
        .fpos_i       (fpos),
        .left_i       (cur_left),
        .right_i      (cur_right),
        .len_i        (cur_len),
        .sdata_o      (sdata_o)
    );

    // R10: the handshake only opens on a bit-clock fall.
    p_ready_on_fall_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (!bclk_i && $past(bclk_i)));

endmodule

// File: tb/audio_fmt_tx_tb.sv
module audio_fmt_tx_tb;
    localparam int DW   = 32;
    localparam int HB   = 32;
    localparam int PMAX = (1 << $clog2(2 * HB + 1)) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    cfg = 6'd0;
    logic          bclk = 1'b0;
    logic          lrclk = 1'b0;
    logic          s_valid = 1'b0;
    logic [DW-1:0] s_left = '0;
    logic [DW-1:0] s_right = '0;
    wire           s_ready;
    wire           sdata;
    wire           underflow;

    always #10 clk = ~clk;

    audio_fmt_tx #(.DW(DW), .HALF_BITS(HB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .bclk_i(bclk), .lrclk_i(lrclk),
        .s_valid_i(s_valid), .s_ready_o(s_ready), .s_left_i(s_left),
        .s_right_i(s_right), .sdata_o(sdata), .underflow_o(underflow)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit feed_en = 1'b0;
    string cur_tag = "R1";
    logic [DW-1:0] q_l[$];
    logic [DW-1:0] q_r[$];

    // Reference model state.
    bit            m_bp, m_lp, exp_sd, exp_uf, exp_rdy;
    int            m_hp, m_fp, m_len;
    logic [DW-1:0] m_l, m_r;

    task automatic check(input bit act, input bit exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0b expected=%0b t=%0t", what, cur_tag, act, exp, $time);
        end
    endtask

    function automatic int wbits(input int code);
        case (code)
            0: return 16;
            1: return 20;
            2: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic bit bit_of(input logic [DW-1:0] w, input int idx);
        logic [DW-1:0] t;
        t = w >> idx;
        return t[0];
    endfunction

    // One model step for the coming clock edge, from the inputs now applied.
    task automatic model_step();
        bit fall, hs, fs, rh, lv, vld;
        int ph, pf, w, fmt;
        logic [DW-1:0] wd;
        exp_rdy = 1'b0;
        if (!rst_n) begin
            m_bp = 0; m_lp = 0; m_hp = PMAX; m_fp = PMAX;
            m_l = '0; m_r = '0; m_len = 0; exp_sd = 0; exp_uf = 0;
            return;
        end
        fmt  = int'(cfg[1:0]);
        lv   = lrclk;
        vld  = s_valid;
        fall = m_bp && !bclk;
        fs   = 1'b0;
        if (fall) begin
            hs = (lv != m_lp);
            if (fmt == 3) fs = lv && !m_lp;
            else          fs = hs && (lv == cfg[4]);
            ph = hs ? 0 : ((m_hp >= PMAX) ? PMAX : m_hp + 1);
            pf = fs ? 0 : ((m_fp >= PMAX) ? PMAX : m_fp + 1);
            if (fs) begin
                exp_rdy = 1'b1;
                m_len = int'(cfg[3:2]);
                if (vld) begin
                    m_l = cfg[5] ? q_r[0] : q_l[0];
                    m_r = cfg[5] ? q_l[0] : q_r[0];
                    void'(q_l.pop_front());
                    void'(q_r.pop_front());
                end else begin
                    m_l = '0;
                    m_r = '0;
                end
            end
            w  = wbits(m_len);
            rh = (lv != cfg[4]);
            wd = rh ? m_r : m_l;
            exp_sd = 1'b0;
            if (fmt == 1 && ph < w) exp_sd = bit_of(wd, w - 1 - ph);
            if (fmt == 2 && ph >= 1 && ph <= w) exp_sd = bit_of(wd, w - ph);
            if (fmt == 0 && ph >= HB - w && ph < HB) exp_sd = bit_of(wd, HB - 1 - ph);
            if (fmt == 3 && pf >= 1 && pf <= w) exp_sd = bit_of(m_l, w - pf);
            if (fmt == 3 && pf > w && pf <= 2 * w) exp_sd = bit_of(m_r, 2 * w - pf);
            m_lp = lv;
            m_hp = ph;
            m_fp = pf;
        end
        exp_uf = fs && !vld;
        m_bp = bclk;
    endtask

    // One system clock cycle: check last edge's outputs, drive, predict.
    task automatic tick(input bit b, input bit l);
        @(negedge clk);
        check(sdata, exp_sd, "R2 R12 sdata");
        check(underflow, exp_uf, "R11 underflow");
        bclk = b;
        lrclk = l;
        s_valid = feed_en && (q_l.size() > 0);
        s_left = (q_l.size() > 0) ? q_l[0] : '0;
        s_right = (q_r.size() > 0) ? q_r[0] : '0;
        #1;
        model_step();
        check(s_ready, exp_rdy, "R10 ready");
    endtask

    task automatic run_frames(input string tag, input logic [5:0] c, input int frames,
                              input bit feed, input int mid_len);
        bit lv;
        cur_tag = tag;
        cfg = c;
        feed_en = feed;
        for (int f = 0; f < frames; f++) begin
            if (feed) begin
                q_l.push_back($urandom());
                q_r.push_back($urandom());
            end
            for (int k = 0; k < 2 * HB; k++) begin
                if (cfg[1:0] == 2'd3) lv = (k == 0);
                else                  lv = (k < HB) ? cfg[4] : !cfg[4];
                if (k == 40 && mid_len >= 0 && f == 0) cfg[3:2] = 2'(mid_len);
                for (int cy = 0; cy < 4; cy++) tick(cy >= 2, lv);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        model_step();
        for (int i = 0; i < 5; i++) tick(1'b0, 1'b0);
        // R1: reset state at the ports
        check(sdata, 1'b0, "R1 sdata in reset");
        check(underflow, 1'b0, "R1 underflow in reset");
        check(s_ready, 1'b0, "R1 ready in reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        model_step();
        tick(1'b0, 1'b0);
        check(sdata, 1'b0, "R1 sdata after reset");
        // cfg = {swap, phase, len, fmt}
        run_frames("R3 R7 lj16",          6'b0_0_00_01, 3, 1'b1, -1);
        run_frames("R3 R8 lj32 swap",     6'b1_0_11_01, 3, 1'b1, -1);
        run_frames("R4 R7 i2s24",         6'b0_0_10_10, 3, 1'b1, -1);
        run_frames("R4 R9 i2s16 phase",   6'b0_1_00_10, 3, 1'b1, -1);
        run_frames("R5 R7 rj20",          6'b0_1_01_00, 3, 1'b1, -1);
        run_frames("R5 R8 R9 rj32",       6'b1_1_11_00, 3, 1'b1, -1);
        run_frames("R5 R9 rj16 phase0",   6'b0_0_00_00, 3, 1'b1, -1);
        run_frames("R6 dsp16",            6'b0_0_00_11, 3, 1'b1, -1);
        run_frames("R6 R8 dsp24 swap",    6'b1_0_10_11, 3, 1'b1, -1);
        run_frames("R7 midframe length",  6'b0_0_00_01, 3, 1'b1, 3);
        run_frames("R11 R10 starved",     6'b0_0_00_01, 3, 1'b0, -1);
        run_frames("R10 R11 recover",     6'b0_0_01_10, 3, 1'b1, -1);
        tick(1'b0, 1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule